// File: doc/BRIEF.md
# Temperature Conversion and Limit Monitor

This block paces a temperature converter and judges every finished reading against three programmable thresholds. A one-cycle start pulse is issued right after reset and then once every `PERIOD_CYC` clock cycles. With the default of 5,000,000 cycles, that is 100 ms at 50 MHz, or ten conversions per second. The converter returns each signed 12-bit result (0.0625 °C per LSB) over a valid/ready stream. The block keeps the most recent accepted result and raises a sticky valid flag on the first one.

Each accepted result is compared against a high limit, a low limit and a separate critical limit. When the event output is enabled and any of these limits is violated, the block drives an active-high pull-down enable. That enable controls an open-drain style alarm line, which is only ever pulled low or released. Limits and the enable bit are loaded through a plain single-cycle write port.

Back-pressure rules for the result stream:
- `conv_ready` goes high together with a start pulse and stays high until one result is taken.
- A result is taken on a clock edge where both `conv_valid` and `conv_ready` are high.
- A result offered while `conv_ready` is low is dropped without effect.

This means no result is reported until a conversion that began after reset has finished.

Top module: `temp_limit_monitor`

## Requirements
- R1: While `rst_n` is low, `conv_start`, `conv_ready`, `reading_valid` and `event_pull` are all 0, and `reading` is 0.
- R2: With no host action, the first `conv_start` pulse appears in the first cycle after the first clock edge following reset release. `conv_ready` rises only in a cycle where `conv_start` is high.
- R3: `conv_start` is a single-cycle pulse. Consecutive pulses are exactly `PERIOD_CYC` cycles apart.
- R4: A result is accepted only on an edge where `conv_valid` and `conv_ready` are both 1. `conv_ready` then falls until the next start. An offer made while `conv_ready` is 0 leaves `reading` unchanged.
- R5: An accepted `conv_data` appears on `reading` in the next cycle. `reading_valid` becomes 1 at that point and stays 1 until reset.
- R6: A reading strictly greater than the high limit sets the event condition. A reading equal to the high limit does not.
- R7: A reading strictly less than the low limit sets the event condition. A reading equal to the low limit does not.
- R8: A reading greater than or equal to the critical limit sets the event condition.
- R9: The write port maps addresses as follows: address 0 is the high limit, 1 is the low limit, 2 is the critical limit, and 3 is control, where bit 0 is the event enable (reset 0). `event_pull` is 1 only when the enable is 1 and the latest reading violates a limit.
- R10: A limit write made while a conversion is outstanding does not lower `conv_ready` and does not shift the start schedule. The next accepted reading is compared against the newly written value.
- R11: Readings and limits are 12-bit two's-complement values, so a negative reading compares as below a positive limit. Reset limits are: high 0x7FF, low 0x800, critical 0x7FF.
- R12: The event condition is re-evaluated only when a reading is accepted. A limit write alone does not change it, and an in-range reading clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | output | 1 | One-cycle pulse that begins a conversion |
| conv_valid | input | 1 | Converter result is present |
| conv_ready | output | 1 | Block will take a result (conversion outstanding) |
| conv_data | input | 12 | Signed converter result, 0.0625 °C per LSB |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 high, 1 low, 2 critical, 3 control) |
| wr_data | input | 12 | Write data; control uses bit 0 only |
| reading | output | 12 | Latest accepted reading |
| reading_valid | output | 1 | A reading has been accepted since reset |
| event_pull | output | 1 | Pull the open-drain alarm line low |

## Verification
The assertions assume that the converter drives `conv_valid` and `conv_data` only from clock-synchronous logic. They also assume that `PERIOD_CYC` is at least 2, so that successive start pulses never merge. The stimulus respects this in three ways:
- It changes every input on the falling clock edge.
- It holds `conv_valid` for exactly one cycle per offer.
- It uses a 16-cycle period.

The stimulus also makes deliberate offers while `conv_ready` is low, which tests the handshake's drop rule.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int unsigned TEMP_W = 12;
  localparam int unsigned NUM_LIMITS = 3;

  typedef logic signed [TEMP_W-1:0] temp_t;

  typedef enum logic [1:0] {
    SEL_HIGH = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_CRIT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [TEMP_W-1:0] hi;
    logic [TEMP_W-1:0] lo;
    logic [TEMP_W-1:0] crit;
    logic              en;
  } limits_t;

  function automatic logic [TEMP_W-1:0] limit_reset(input int idx);
    case (idx)
      0:       return {1'b0, {(TEMP_W-1){1'b1}}};
      1:       return {1'b1, {(TEMP_W-1){1'b0}}};
      default: return {1'b0, {(TEMP_W-1){1'b1}}};
    endcase
  endfunction
endpackage

// File: rtl/tlm_sched.sv
module tlm_sched #(
  parameter int unsigned PERIOD_CYC = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic conv_start,
  output logic busy
);
  localparam int unsigned CNT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             issue;

  assign issue = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      conv_start <= 1'b0;
      busy       <= 1'b0;
    end else begin
      conv_start <= issue;
      cnt        <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (issue)
        busy <= 1'b1;
      else if (accept)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/tlm_regs.sv
module tlm_regs
  import tlm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TEMP_W-1:0] wr_data,
  output limits_t           lim
);
  logic [NUM_LIMITS-1:0][TEMP_W-1:0] slot;
  logic                              en_q;

  for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[g] <= limit_reset(g);
      else if (wr_en && (wr_addr == 2'(g)))
        slot[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= 1'b0;
    else if (wr_en && (wr_addr == SEL_CTRL))
      en_q <= wr_data[0];
  end

  assign lim.hi   = slot[SEL_HIGH];
  assign lim.lo   = slot[SEL_LOW];
  assign lim.crit = slot[SEL_CRIT];
  assign lim.en   = en_q;
endmodule

// File: rtl/tlm_cmp.sv
module tlm_cmp
  import tlm_pkg::*;
(
  input  logic [TEMP_W-1:0] sample,
  input  limits_t           lim,
  output logic              hit
);
  temp_t s, h, l, c;
  logic  over_hi, under_lo, at_crit;

  assign s = temp_t'(sample);
  assign h = temp_t'(lim.hi);
  assign l = temp_t'(lim.lo);
  assign c = temp_t'(lim.crit);

  assign over_hi  = (s > h);
  assign under_lo = (s < l);
  assign at_crit  = (s >= c);
  assign hit      = over_hi | under_lo | at_crit;
endmodule

// File: rtl/temp_limit_monitor.sv
module temp_limit_monitor
  import tlm_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 5_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              conv_start,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [TEMP_W-1:0] conv_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TEMP_W-1:0] wr_data,
  output logic [TEMP_W-1:0] reading,
  output logic              reading_valid,
  output logic              event_pull
);
  logic    accept;
  logic    hit;
  logic    flag_q;
  limits_t lim;

  assign accept = conv_valid & conv_ready;

  tlm_sched #(.PERIOD_CYC(PERIOD_CYC)) sched_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .conv_start (conv_start),
    .busy       (conv_ready)
  );

  tlm_regs regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lim     (lim)
  );

  tlm_cmp cmp_i (
    .sample (conv_data),
    .lim    (lim),
    .hit    (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reading       <= '0;
      reading_valid <= 1'b0;
      flag_q        <= 1'b0;
    end else if (accept) begin
      reading       <= conv_data;
      reading_valid <= 1'b1;
      flag_q        <= hit;
    end
  end

  assign event_pull = flag_q & lim.en;
endmodule

// File: rtl/tlm_checker.sv
module tlm_checker #(
  parameter int unsigned PERIOD_CYC = 5_000_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        conv_start,
  input logic        conv_valid,
  input logic        conv_ready,
  input logic [11:0] conv_data,
  input logic [11:0] reading,
  input logic        reading_valid,
  input logic        event_pull
);
  localparam int unsigned GW = $clog2(PERIOD_CYC + 1) + 1;
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (conv_start) begin
      gap  <= GW'(1);
      seen <= 1'b1;
    end else if (gap != GMAX) begin
      gap <= gap + 1'b1;
    end
  end

  a_r2_ready_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_ready) |-> conv_start);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r3_period: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && seen) |-> (gap == GW'(PERIOD_CYC)));

  a_r4_hold_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_valid && conv_ready) |=> $stable(reading));

  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready && !conv_start) |=> !conv_ready);

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready) |=> (reading_valid && reading == $past(conv_data)));

  a_r5_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    reading_valid |=> reading_valid);

  a_r9_event_needs_reading: assert property (@(posedge clk) disable iff (!rst_n)
    event_pull |-> reading_valid);
endmodule

bind temp_limit_monitor tlm_checker #(.PERIOD_CYC(PERIOD_CYC)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .conv_start    (conv_start),
  .conv_valid    (conv_valid),
  .conv_ready    (conv_ready),
  .conv_data     (conv_data),
  .reading       (reading),
  .reading_valid (reading_valid),
  .event_pull    (event_pull)
);

// File: tb/temp_limit_monitor_tb_top.sv
module temp_limit_monitor_tb_top;
  localparam int unsigned PERIOD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start, conv_ready, reading_valid, event_pull;
  logic        conv_valid = 1'b0;
  logic [11:0] conv_data = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [11:0] reading;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int hi_v = 2047, lo_v = -2048, crit_v = 2047;
  logic en_v = 1'b0;

  always #10 clk = ~clk;

  temp_limit_monitor #(.PERIOD_CYC(PERIOD)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_valid(conv_valid),
    .conv_ready(conv_ready), .conv_data(conv_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reading(reading), .reading_valid(reading_valid),
    .event_pull(event_pull)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190_000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int sx(input logic [11:0] x);
    return x[11] ? int'(x) - 4096 : int'(x);
  endfunction

  function automatic logic exp_evt(input logic [11:0] d);
    int s = sx(d);
    return en_v && ((s > hi_v) || (s < lo_v) || (s >= crit_v));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: hi_v = sx(d);
      2'd1: lo_v = sx(d);
      2'd2: crit_v = sx(d);
      default: en_v = d[0];
    endcase
  endtask

  task automatic conv(input logic [11:0] d, input string req);
    @(negedge clk);
    while (!conv_ready) @(negedge clk);
    conv_valid = 1'b1; conv_data = d;
    @(negedge clk);
    conv_valid = 1'b0;
    chk({req, " reading"}, int'(reading), int'(d));
    chk({req, " event"}, int'(event_pull), int'(exp_evt(d)));
  endtask

  initial begin
    int gap;
    logic [11:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start", conv_start, 0);
    chk("R1 ready", conv_ready, 0);
    chk("R1 valid", reading_valid, 0);
    chk("R1 event", event_pull, 0);
    chk("R1 reading", reading, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 first start without command
    chk("R2 first start", conv_start, 1);
    chk("R2 ready", conv_ready, 1);
    chk("R5 no valid yet", reading_valid, 0);
    // R3 period
    gap = 0;
    do begin @(negedge clk); gap++; end while (!conv_start);
    chk("R3 period", gap, PERIOD);
    // R11 reset limits: 0x7FF hits critical, 0 in range (enable on)
    wr(2'd3, 12'd1);
    conv(12'h000, "R11 reset limits in range");
    chk("R5 valid set", reading_valid, 1);
    conv(12'h7FF, "R11 reset crit");
    // R4 offer while not ready is dropped
    @(negedge clk);
    held = reading;
    chk("R4 ready low", conv_ready, 0);
    conv_valid = 1'b1; conv_data = 12'h123;
    @(negedge clk);
    conv_valid = 1'b0;
    chk("R4 ignored", int'(reading), int'(held));
    // Full sweep: hi 25C, lo -16C, crit 80C (R6 R7 R8 R11)
    wr(2'd0, 12'd400);
    wr(2'd1, 12'hF00);
    wr(2'd2, 12'd1280);
    for (int v = 0; v < 4096; v++) conv(12'(v), "R6 R7 R8 R11 sweep");
    // R12 limit write alone does not re-evaluate
    conv(12'd500, "R6 over high");
    chk("R12 event set", event_pull, 1);
    wr(2'd0, 12'd1000);
    @(negedge clk);
    chk("R12 held after write", event_pull, 1);
    conv(12'd10, "R12 in range clears");
    // R10 write while conversion outstanding
    @(negedge clk);
    while (!conv_ready) @(negedge clk);
    wr(2'd0, 12'd0);
    chk("R10 ready kept", conv_ready, 1);
    conv(12'd5, "R10 new high used");
    gap = 0;
    @(negedge clk);
    while (!conv_start) @(negedge clk);
    do begin @(negedge clk); gap++; end while (!conv_start);
    chk("R10 schedule kept", gap, PERIOD);
    // R9 enable off: event never pulled
    wr(2'd3, 12'd0);
    chk("R9 disable releases", event_pull, 0);
    for (int v = 0; v < 4096; v += 64) conv(12'(v), "R9 disabled");
    wr(2'd3, 12'd1);
    conv(12'd2000, "R9 re-enabled");
    chk("R5 valid sticky", reading_valid, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule